// File: doc/BRIEF.md
# Masked Fuse Row Read Filter

This block serves software reads of a one-time-programmable fuse store. Writing a word to the read-address register selects a logical array and a row. In the same cycle the block turns that selection into a physical array and row request toward the fuse storage. On the next clock edge it latches the returned 32-bit row into a read-only read-data register. Before the value is stored, columns are hidden by a hard-wired visibility mask that depends on the row.

Some rows hold secrets, such as key material, and some rows are simply not mapped. A read of such a row is refused: the data register is loaded with zero and an error event is raised. A permitted read raises a done event. Both events are single-cycle pulses toward a separate interrupt-status block. That block sets its done flag and clears its error flag on a done pulse, and does the reverse on an error pulse. A refused read therefore never causes a bus error.

Top module: `fuse_rd_filter`

## Requirements
- R1: The address word carries the array select in bits 12..11 and the row in bits 10..5. The readback register `rdAddr` keeps only these two fields from the last write, and every other bit reads zero, including reserved bits 4..0.
- R2: Logical arrays 2 and 3 are requested from physical arrays 1 and 2 on `fuseArray`, with all 32 columns visible. Logical array 0 maps to physical array 0. `fuseRow` always equals the addressed row.
- R3: In array 0, row 0 exposes only columns 28..31. Rows 8..15, 20, 22, 23 and 40..63 expose all 32 columns.
- R4: In array 0, row 16 exposes columns 0..7 and 10..16 (mask 0x0001FCFF). Row 17 exposes columns 0..2 (mask 0x00000007). Row 21 exposes columns 0..23 and 29..31 (mask 0xE0FFFFFF).
- R5: These reads are denied:
  - any read of logical array 1;
  - any read of an array 0 row whose mask is zero, which covers rows 1..7, 18, 19 and 24..39;
  - any row at or beyond the row count.
- R6: A granted read loads `rdData` with the row value ANDed with its mask, pulses `rdDone` for one cycle and keeps `rdErr` low.
- R7: A denied read loads `rdData` with zero, pulses `rdErr` for one cycle and keeps `rdDone` low.
- R8: The result and its event pulse appear on the first clock edge after the cycle in which `addrWrValid` is high. Back-to-back writes each produce their own result. Exactly one of `rdDone` and `rdErr` is high per write.
- R9: `rdData` holds its value until the next address write. Reset clears `rdData`, `rdAddr`, `rdDone` and `rdErr` to zero, and no pulse occurs without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrWrValid | input | 1 | One-cycle strobe: a write to the read-address register |
| addrWrData | input | 32 | Written address word |
| fuseRowData | input | 32 | Row value returned by the fuse storage for the current request |
| fuseArray | output | 2 | Physical array requested from the fuse storage |
| fuseRow | output | 6 | Row requested from the fuse storage |
| rdAddr | output | 32 | Readback of the read-address register |
| rdData | output | 32 | Read-only read-data register |
| rdDone | output | 1 | Pulse: granted read completed |
| rdErr | output | 1 | Pulse: read denied |

## Verification
The assertions assume that the fuse storage answers combinationally in the same cycle as the request, and that `addrWrValid` is never high while reset is asserted. The bench models the storage as a pure function of the physical array and row, so it always answers in the same cycle. It drives `addrWrValid` only after reset has been released, at a falling edge. It then sweeps every array and row combination, both back-to-back and with idle gaps. Junk is placed in the reserved and upper address bits throughout the sweep.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

  localparam int DATA_W = 32;
  localparam int HELPER_FIRST = 2;  // first logical array backed by a shifted physical array
  localparam int HELPER_LAST  = 3;

  typedef struct packed {
    logic              load;   // address write seen this cycle
    logic              grant;  // read permitted
    logic [DATA_W-1:0] mask;   // visible columns
  } rdStrobe_t;

  function automatic logic [DATA_W-1:0] colSpan(input int lo, input int hi);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int c = 0; c < DATA_W; c++) begin
      if (c >= lo && c <= hi) m[c] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] rowMask(input int row);
    logic [DATA_W-1:0] m;
    m = '0;
    if (row == 0)                                    m = colSpan(28, 31);
    else if (row inside {[8:15], 20, 22, 23, [40:63]}) m = colSpan(0, DATA_W-1);
    else if (row == 16)                              m = colSpan(0, 7) | colSpan(10, 16);
    else if (row == 17)                              m = colSpan(0, 2);
    else if (row == 21)                              m = colSpan(0, 23) | colSpan(29, 31);
    return m;
  endfunction

endpackage

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
  import fuse_rd_pkg::*;
#(
  parameter int ARRAY_W   = 2,
  parameter int ROW_W     = 6,
  parameter int ARRAY_LSB = 11,
  parameter int ROW_LSB   = 5,
  parameter int NUM_ROWS  = 64
) (
  input  logic               addrWrValid,
  input  logic [DATA_W-1:0]  addrWrData,
  output logic [ARRAY_W-1:0] arrSel,
  output logic [ROW_W-1:0]   rowSel,
  output logic [ARRAY_W-1:0] fuseArray,
  output logic [ROW_W-1:0]   fuseRow,
  output rdStrobe_t          strobe
);

  localparam int TBL_ROWS = 1 << ROW_W;

  logic [DATA_W-1:0] maskTbl [TBL_ROWS];

  assign arrSel  = addrWrData[ARRAY_LSB +: ARRAY_W];
  assign rowSel  = addrWrData[ROW_LSB +: ROW_W];
  assign fuseRow = rowSel;

  for (genvar r = 0; r < TBL_ROWS; r++) begin : g_mask
    if (r < NUM_ROWS) begin : g_mapped
      assign maskTbl[r] = rowMask(r);
    end else begin : g_unmapped
      assign maskTbl[r] = '0;
    end
  end

  always_comb begin
    strobe.load  = addrWrValid;
    strobe.grant = 1'b0;
    strobe.mask  = '0;
    fuseArray    = '0;
    if (arrSel == '0) begin
      strobe.mask  = maskTbl[rowSel];
      strobe.grant = |maskTbl[rowSel];
    end else if (int'(arrSel) >= HELPER_FIRST && int'(arrSel) <= HELPER_LAST) begin
      fuseArray    = arrSel - ARRAY_W'(1);
      strobe.mask  = '1;
      strobe.grant = 1'b1;
    end
  end

endmodule

// File: rtl/fuse_rd_dp.sv
module fuse_rd_dp
  import fuse_rd_pkg::*;
#(
  parameter int ARRAY_W   = 2,
  parameter int ROW_W     = 6,
  parameter int ARRAY_LSB = 11,
  parameter int ROW_LSB   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  rdStrobe_t          strobe,
  input  logic [ARRAY_W-1:0] arrSel,
  input  logic [ROW_W-1:0]   rowSel,
  input  logic [DATA_W-1:0]  fuseRowData,
  output logic [DATA_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdDone,
  output logic               rdErr
);

  logic [DATA_W-1:0] nextAddr;

  always_comb begin
    nextAddr = '0;
    nextAddr[ARRAY_LSB +: ARRAY_W] = arrSel;
    nextAddr[ROW_LSB +: ROW_W]     = rowSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr <= '0;
      rdData <= '0;
      rdDone <= 1'b0;
      rdErr  <= 1'b0;
    end else begin
      rdDone <= strobe.load && strobe.grant;
      rdErr  <= strobe.load && !strobe.grant;
      if (strobe.load) begin
        rdAddr <= nextAddr;
        rdData <= strobe.grant ? (fuseRowData & strobe.mask) : '0;
      end
    end
  end

endmodule

// File: rtl/fuse_rd_filter.sv
module fuse_rd_filter
  import fuse_rd_pkg::*;
#(
  parameter int ARRAY_W   = 2,
  parameter int ROW_W     = 6,
  parameter int ARRAY_LSB = 11,
  parameter int ROW_LSB   = 5,
  parameter int NUM_ROWS  = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               addrWrValid,
  input  logic [31:0]        addrWrData,
  input  logic [31:0]        fuseRowData,
  output logic [ARRAY_W-1:0] fuseArray,
  output logic [ROW_W-1:0]   fuseRow,
  output logic [31:0]        rdAddr,
  output logic [31:0]        rdData,
  output logic               rdDone,
  output logic               rdErr
);

  rdStrobe_t          strobe;
  logic [ARRAY_W-1:0] arrSel;
  logic [ROW_W-1:0]   rowSel;

  fuse_rd_ctrl #(
    .ARRAY_W(ARRAY_W), .ROW_W(ROW_W), .ARRAY_LSB(ARRAY_LSB),
    .ROW_LSB(ROW_LSB), .NUM_ROWS(NUM_ROWS)
  ) ctrl_i (
    .addrWrValid(addrWrValid), .addrWrData(addrWrData),
    .arrSel(arrSel), .rowSel(rowSel),
    .fuseArray(fuseArray), .fuseRow(fuseRow), .strobe(strobe)
  );

  fuse_rd_dp #(
    .ARRAY_W(ARRAY_W), .ROW_W(ROW_W), .ARRAY_LSB(ARRAY_LSB), .ROW_LSB(ROW_LSB)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .arrSel(arrSel), .rowSel(rowSel), .fuseRowData(fuseRowData),
    .rdAddr(rdAddr), .rdData(rdData), .rdDone(rdDone), .rdErr(rdErr)
  );

endmodule

// File: rtl/fuse_rd_filter_chk.sv
module fuse_rd_filter_chk #(
  parameter int ARRAY_W   = 2,
  parameter int ROW_W     = 6,
  parameter int ARRAY_LSB = 11,
  parameter int ROW_LSB   = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               addrWrValid,
  input logic [31:0]        addrWrData,
  input logic [ARRAY_W-1:0] fuseArray,
  input logic [ROW_W-1:0]   fuseRow,
  input logic [31:0]        rdAddr,
  input logic [31:0]        rdData,
  input logic               rdDone,
  input logic               rdErr
);

  logic [ARRAY_W-1:0] inArr;
  logic [ROW_W-1:0]   inRow;
  assign inArr = addrWrData[ARRAY_LSB +: ARRAY_W];
  assign inRow = addrWrData[ROW_LSB +: ROW_W];

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdAddr[ROW_LSB-1:0] == '0);

  a_r2_remap: assert property (@(posedge clk) disable iff (!rstN)
    (addrWrValid && inArr == ARRAY_W'(2)) |-> (fuseArray == ARRAY_W'(1) && fuseRow == inRow));

  a_r5_array1_denied: assert property (@(posedge clk) disable iff (!rstN)
    (addrWrValid && inArr == ARRAY_W'(1)) |=> rdErr);

  a_r7_denied_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> rdData == '0);

  a_r8_one_event: assert property (@(posedge clk) disable iff (!rstN)
    $countones({rdDone, rdErr}) <= 1);

  a_r8_event_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    (rdDone || rdErr) |-> $past(addrWrValid));

  a_r8_write_gives_event: assert property (@(posedge clk) disable iff (!rstN)
    addrWrValid |=> (rdDone || rdErr));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(addrWrValid) |-> ($stable(rdData) && $stable(rdAddr)));

endmodule

bind fuse_rd_filter fuse_rd_filter_chk #(
  .ARRAY_W(ARRAY_W), .ROW_W(ROW_W), .ARRAY_LSB(ARRAY_LSB), .ROW_LSB(ROW_LSB)
) chk_i (
  .clk(clk), .rstN(rstN), .addrWrValid(addrWrValid), .addrWrData(addrWrData),
  .fuseArray(fuseArray), .fuseRow(fuseRow), .rdAddr(rdAddr), .rdData(rdData),
  .rdDone(rdDone), .rdErr(rdErr)
);

// File: tb/fuse_rd_filter_tb.sv
`timescale 1ns/1ps
module fuse_rd_filter_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrWrValid = 1'b0;
  logic [31:0] addrWrData = '0;
  logic [31:0] fuseRowData;
  logic [1:0]  fuseArray;
  logic [5:0]  fuseRow;
  logic [31:0] rdAddr, rdData;
  logic        rdDone, rdErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] expAddr = '0, expData = '0;
  logic        expDone = 0, expErr = 0;

  always #4 clk = ~clk;

  // fuse storage stand-in: pure function of physical array and row
  function automatic logic [31:0] fuseVal(input int a, input int r);
    return ((a * 64 + r + 1) * 32'h9E3779B1) ^ 32'h5A3C96E1;
  endfunction

  assign fuseRowData = fuseVal(int'(fuseArray), int'(fuseRow));

  fuse_rd_filter dut_i (
    .clk(clk), .rstN(rstN), .addrWrValid(addrWrValid), .addrWrData(addrWrData),
    .fuseRowData(fuseRowData), .fuseArray(fuseArray), .fuseRow(fuseRow),
    .rdAddr(rdAddr), .rdData(rdData), .rdDone(rdDone), .rdErr(rdErr)
  );

  function automatic bit colVisible(input int row, input int col);
    if (row == 0) return col >= 28;
    if ((row >= 8 && row <= 15) || row == 20 || row == 22 || row == 23 || row >= 40) return 1;
    if (row == 16) return col <= 7 || (col >= 10 && col <= 16);
    if (row == 17) return col <= 2;
    if (row == 21) return col <= 23 || col >= 29;
    return 0;
  endfunction

  function automatic logic [31:0] refMask(input int row);
    logic [31:0] m = '0;
    for (int c = 0; c < 32; c++) m[c] = colVisible(row, c);
    return m;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] d, input string tag);
    int a, r, phys;
    logic [31:0] m;
    addrWrValid = v;
    addrWrData  = d;
    a = int'(d[12:11]);
    r = int'(d[10:5]);
    #1;
    if (v && a != 1) begin
      phys = (a == 0) ? 0 : a - 1;
      check("R2", "fuseArray", 32'(fuseArray), 32'(phys));
      check("R2", "fuseRow", 32'(fuseRow), 32'(r));
    end
    if (v) begin
      expAddr = d & 32'h0000_1FE0;
      m = (a == 0) ? refMask(r) : 32'hFFFF_FFFF;
      if (a == 1 || m == 0) begin
        expData = '0; expDone = 0; expErr = 1;
      end else begin
        phys = (a == 0) ? 0 : a - 1;
        expData = fuseVal(phys, r) & m; expDone = 1; expErr = 0;
      end
    end else begin
      expDone = 0; expErr = 0;
    end
    @(negedge clk);
    addrWrValid = 1'b0;
    check("R1", "rdAddr", rdAddr, expAddr);
    check(tag, "rdData", rdData, expData);
    check(v ? "R8" : "R9", "rdDone", 32'(rdDone), 32'(expDone));
    check(v ? "R8" : "R9", "rdErr", 32'(rdErr), 32'(expErr));
    if (v) check(expErr ? "R7" : "R6", "event", {30'b0, rdErr, rdDone}, {30'b0, expErr, expDone});
  endtask

  function automatic string tagFor(input int a, input int r);
    if (a == 1) return "R5";
    if (a >= 2) return "R2";
    if (r == 16 || r == 17 || r == 21) return "R4";
    if (refMask(r) != 0) return "R3";
    return "R5";
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    expAddr = '0; expData = '0; expDone = 0; expErr = 0;
    check("R9", "rdData reset", rdData, 32'h0);
    check("R9", "rdAddr reset", rdAddr, 32'h0);
    check("R9", "pulses reset", {30'b0, rdErr, rdDone}, 32'h0);
    rstN = 1'b1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    doReset();
    repeat (3) step(1'b0, 32'hFFFF_FFFF, "R9");
    // full sweep with junk in reserved and upper bits
    for (int a = 0; a < 4; a++) begin
      for (int r = 0; r < 64; r++) begin
        logic [31:0] junk;
        junk = (32'(a * 64 + r) * 32'h0101_0007) & 32'hFFFF_E01F;
        step(1'b1, junk | 32'(a << 11) | 32'(r << 5), tagFor(a, r));
        if ((r % 5) == 4) begin
          step(1'b0, 32'h0000_1FFF, "R9");
          step(1'b0, 32'h0000_0820, "R9");
        end
      end
    end
    // explicit corner reads: R4 partial rows, R5 key row, R2 helper array
    step(1'b1, 32'h0000_0000 | (16 << 5), "R4");
    step(1'b1, 32'h0000_0000 | (24 << 5), "R5");
    step(1'b1, 32'h0000_1000 | (63 << 5) | 5'h1F, "R2");
    step(1'b1, 32'h0000_0000 | (21 << 5), "R4");
    step(1'b0, 32'h0, "R9");
    doReset();
    step(1'b0, 32'h0, "R9");
    step(1'b1, 32'h0000_0000 | (17 << 5), "R4");
    step(1'b1, 32'h0000_0800 | (9 << 5), "R5");
    step(1'b1, 32'h0000_0000, "R3");
    step(1'b0, 32'h0, "R9");
    finished = 1;
    summary();
    $finish;
  end

endmodule